// File: doc/BRIEF.md
# Cache Miss Latency Sequencer

This block is a timing model of a read travelling down a three-level cache hierarchy. Each read is marked as either an instruction fetch or a data load. It comes with three hit flags, one per level. The block does no real lookup. It walks the read through fixed-length pipeline phases and raises a one-cycle completion pulse in the exact cycle the result would become usable. It also reports how many cycles the last completed read took.

The path depends on the flags and on the read kind:

- **First-level hit.** The read finishes after a short fixed delay.
- **First-level miss.** The read goes through tag miss detection, core-side arbitration and memory-subsystem arbitration. The second-level and third-level lookups then start together. The third-level lookup is one cycle longer than the second-level lookup, and its result counts only when the second level misses.
- **Third-level hit.** The read waits for the slower third-level clock, pays an SRAM access of parameterised length, and then returns.
- **Miss at every level.** The block raises a memory-miss pulse instead of completing.

Only one read is in flight at a time. A performance model or an arbitration testbench uses the block as a latency oracle: present a read while ready is high, then observe the completion pulse.

Top module: `cacheMissSeq`

## Requirements
- R1: While reset is asserted and right after it, reqReady is 1, respDone and memMiss are 0, and lastLatency is 0.
- R2: A read is accepted at a rising edge where reqValid and reqReady are both 1. From the next cycle reqReady stays 0 until the read ends. reqValid and the flags presented while reqReady is 0 are ignored.
- R3: With l1Hit=1, respDone rises 2 edges after acceptance for an instruction fetch (reqIsData=0) and 3 edges after acceptance for a data load (reqIsData=1).
- R4: An instruction fetch with l1Hit=0 and l2Hit=1 completes 13 edges after acceptance (2 tag, 3 core arbitration, 1 subsystem arbitration, 3 lookup, 4 return).
- R5: A data load with l1Hit=0 and l2Hit=1 completes 9 edges after acceptance (2 tag, 1 core arbitration, 1 subsystem arbitration, 3 lookup, 2 return).
- R6: When l1Hit=0, l2Hit=0 and l3Hit=1, the read completes 37+A edges after acceptance for an instruction fetch and 33+A for a data load. A is the alignment wait, and the SRAM access is SRAM_CYC=23 cycles.
- R7: The third-level lookup ends at edge tL = tA+10 (instruction fetch) or tA+8 (data load), where tA is the acceptance edge. Edges are counted from 1 at the first edge after reset release. The alignment wait is A = (L3_RATIO − tL mod L3_RATIO) mod L3_RATIO, with L3_RATIO=4.
- R8: l1Hit takes priority over l2Hit and l3Hit. When l2Hit=1, the value of l3Hit has no effect on timing.
- R9: When all three flags are 0, memMiss pulses for one cycle at edge tL from R7. respDone stays 0, lastLatency is unchanged, and reqReady returns to 1 in that same cycle.
- R10: respDone is high for exactly one cycle. lastLatency takes the completed read's edge count at that same edge and holds it until the next completion.
- R11: A new read can be accepted at the edge directly after the cycle in which respDone or memMiss is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request present |
| reqIsData | input | 1 | 1 = data load, 0 = instruction fetch |
| l1Hit | input | 1 | First-level hit flag, sampled on acceptance |
| l2Hit | input | 1 | Second-level hit flag, sampled on acceptance |
| l3Hit | input | 1 | Third-level hit flag, sampled on acceptance |
| reqReady | output | 1 | Sequencer idle, able to accept |
| respDone | output | 1 | One-cycle completion pulse |
| memMiss | output | 1 | One-cycle pulse when all levels missed |
| lastLatency | output | LAT_W | Edge count of the last completed read |

## Verification
Any wrong state transition or wrong stage length moves the completion or memory-miss pulse away from its predicted edge. The per-clock comparison against the reference catches that on the very cycle the pulse is early, or on the first cycle it is late. A wrong phase counter or alignment formula shows up only on third-level hits, so those reads are issued after idle gaps of 0 to 3 cycles to produce every alignment wait from 0 to 3. A corrupted latency count shows on lastLatency in the cycle right after completion, and any drift in that value between completions is visible on every compared cycle.

// File: rtl/cmsPkg.sv
package cmsPkg;

  // Fixed phase lengths in processor cycles
  localparam int L1_HIT_INSTR_CYC   = 2;
  localparam int L1_HIT_DATA_CYC    = 3;
  localparam int L1_TAG_CYC         = 2;
  localparam int CORE_ARB_INSTR_CYC = 3;
  localparam int CORE_ARB_DATA_CYC  = 1;
  localparam int MSS_ARB_CYC        = 1;
  localparam int L2_LOOK_CYC        = 3;
  localparam int L3_LOOK_CYC        = 4;
  localparam int RET_INSTR_CYC      = 4;
  localparam int RET_DATA_CYC       = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_L1HIT,
    ST_L1TAG,
    ST_COREARB,
    ST_MSSARB,
    ST_L2LOOK,
    ST_L3LOOK,
    ST_ALIGN,
    ST_SRAM,
    ST_RETURN
  } seqState_e;

  typedef struct packed {
    logic      accept;
    logic      load;
    seqState_e nextStage;
    logic      complete;
    logic      toMemory;
  } ctrlStrobe_t;

endpackage

// File: rtl/cmsDatapath.sv
module cmsDatapath
  import cmsPkg::*;
#(
  parameter int SRAM_CYC = 23,
  parameter int L3_RATIO = 4,
  parameter int LAT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctl,
  input  logic              reqIsData,
  input  logic              l2Hit,
  input  logic              l3Hit,
  output logic              stageLast,
  output logic              alignNeeded,
  output logic              latL2Hit,
  output logic              latL3Hit,
  output logic              respDone,
  output logic              memMiss,
  output logic [LAT_W-1:0]  lastLatency
);

  localparam int MAX_A  = (SRAM_CYC > L3_LOOK_CYC) ? SRAM_CYC : L3_LOOK_CYC;
  localparam int MAXLEN = (MAX_A > L3_RATIO) ? MAX_A : L3_RATIO;
  localparam int CNT_W  = $clog2(MAXLEN + 1);
  localparam int PH_W   = (L3_RATIO > 1) ? $clog2(L3_RATIO) : 1;

  logic [CNT_W-1:0] stageCnt;
  logic [CNT_W-1:0] lenSel;
  logic [CNT_W-1:0] alignCycles;
  logic [LAT_W-1:0] latCnt;
  logic             latData;
  logic             isDataEff;

  // The attribute used for length selection comes from the live inputs on
  // the accept cycle and from the captured copy afterwards.
  assign isDataEff = ctl.accept ? reqIsData : latData;

  // Phase of the slow third-level clock relative to the processor clock
  generate
    if (L3_RATIO > 1) begin : gPhase
      logic [PH_W-1:0] phase;
      logic [PH_W-1:0] phaseNext;
      assign phaseNext = (phase == PH_W'(L3_RATIO - 1)) ? '0 : phase + PH_W'(1);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) phase <= '0;
        else       phase <= phaseNext;
      end
      assign alignCycles = (phaseNext == '0) ? '0
                         : CNT_W'(L3_RATIO) - CNT_W'(phaseNext);
    end else begin : gNoPhase
      assign alignCycles = '0;
    end
  endgenerate

  assign alignNeeded = (alignCycles != '0);

  always_comb begin
    lenSel = '0;
    case (ctl.nextStage)
      ST_L1HIT:   lenSel = isDataEff ? CNT_W'(L1_HIT_DATA_CYC) : CNT_W'(L1_HIT_INSTR_CYC);
      ST_L1TAG:   lenSel = CNT_W'(L1_TAG_CYC);
      ST_COREARB: lenSel = isDataEff ? CNT_W'(CORE_ARB_DATA_CYC) : CNT_W'(CORE_ARB_INSTR_CYC);
      ST_MSSARB:  lenSel = CNT_W'(MSS_ARB_CYC);
      ST_L2LOOK:  lenSel = CNT_W'(L2_LOOK_CYC);
      ST_L3LOOK:  lenSel = CNT_W'(L3_LOOK_CYC);
      ST_ALIGN:   lenSel = alignCycles;
      ST_SRAM:    lenSel = CNT_W'(SRAM_CYC);
      ST_RETURN:  lenSel = isDataEff ? CNT_W'(RET_DATA_CYC) : CNT_W'(RET_INSTR_CYC);
      default:    lenSel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageCnt <= '0;
    end else if (ctl.load) begin
      stageCnt <= lenSel;
    end else if (stageCnt != '0) begin
      stageCnt <= stageCnt - CNT_W'(1);
    end
  end

  assign stageLast = (stageCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latData  <= 1'b0;
      latL2Hit <= 1'b0;
      latL3Hit <= 1'b0;
    end else if (ctl.accept) begin
      latData  <= reqIsData;
      latL2Hit <= l2Hit;
      latL3Hit <= l3Hit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt <= '0;
    end else if (ctl.accept) begin
      latCnt <= '0;
    end else if (latCnt != '1) begin
      latCnt <= latCnt + LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respDone    <= 1'b0;
      memMiss     <= 1'b0;
      lastLatency <= '0;
    end else begin
      respDone <= ctl.complete;
      memMiss  <= ctl.toMemory;
      if (ctl.complete) lastLatency <= latCnt + LAT_W'(1);
    end
  end

endmodule

// File: rtl/cmsControl.sv
module cmsControl
  import cmsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        l1Hit,
  input  logic        latL2Hit,
  input  logic        latL3Hit,
  input  logic        stageLast,
  input  logic        alignNeeded,
  output ctrlStrobe_t ctl,
  output logic        reqReady
);

  seqState_e state;
  seqState_e stNext;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stNext        = state;
    ctl.accept    = 1'b0;
    ctl.load      = 1'b0;
    ctl.nextStage = ST_IDLE;
    ctl.complete  = 1'b0;
    ctl.toMemory  = 1'b0;
    if (state == ST_IDLE) begin
      if (reqValid) begin
        ctl.accept = 1'b1;
        stNext     = l1Hit ? ST_L1HIT : ST_L1TAG;
      end
    end else if (stageLast) begin
      case (state)
        ST_L1HIT, ST_RETURN: begin
          ctl.complete = 1'b1;
          stNext       = ST_IDLE;
        end
        ST_L1TAG:   stNext = ST_COREARB;
        ST_COREARB: stNext = ST_MSSARB;
        ST_MSSARB:  stNext = latL2Hit ? ST_L2LOOK : ST_L3LOOK;
        ST_L2LOOK:  stNext = ST_RETURN;
        ST_L3LOOK: begin
          if (!latL3Hit) begin
            ctl.toMemory = 1'b1;
            stNext       = ST_IDLE;
          end else begin
            stNext = alignNeeded ? ST_ALIGN : ST_SRAM;
          end
        end
        ST_ALIGN:   stNext = ST_SRAM;
        ST_SRAM:    stNext = ST_RETURN;
        default:    stNext = ST_IDLE;
      endcase
    end
    if (stNext != state && stNext != ST_IDLE) begin
      ctl.load      = 1'b1;
      ctl.nextStage = stNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stNext;
  end

endmodule

// File: rtl/cacheMissSeq.sv
module cacheMissSeq
  import cmsPkg::*;
#(
  parameter int SRAM_CYC = 23,
  parameter int L3_RATIO = 4,
  parameter int LAT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqIsData,
  input  logic             l1Hit,
  input  logic             l2Hit,
  input  logic             l3Hit,
  output logic             reqReady,
  output logic             respDone,
  output logic             memMiss,
  output logic [LAT_W-1:0] lastLatency
);

  ctrlStrobe_t ctl;
  logic        stageLast;
  logic        alignNeeded;
  logic        latL2Hit;
  logic        latL3Hit;

  cmsControl u_control (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .l1Hit       (l1Hit),
    .latL2Hit    (latL2Hit),
    .latL3Hit    (latL3Hit),
    .stageLast   (stageLast),
    .alignNeeded (alignNeeded),
    .ctl         (ctl),
    .reqReady    (reqReady)
  );

  cmsDatapath #(
    .SRAM_CYC (SRAM_CYC),
    .L3_RATIO (L3_RATIO),
    .LAT_W    (LAT_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqIsData   (reqIsData),
    .l2Hit       (l2Hit),
    .l3Hit       (l3Hit),
    .stageLast   (stageLast),
    .alignNeeded (alignNeeded),
    .latL2Hit    (latL2Hit),
    .latL3Hit    (latL3Hit),
    .respDone    (respDone),
    .memMiss     (memMiss),
    .lastLatency (lastLatency)
  );

endmodule

// File: rtl/cmsChecker.sv
module cmsChecker #(
  parameter int LAT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             respDone,
  input logic             memMiss,
  input logic [LAT_W-1:0] lastLatency
);

  AST_DONE_NOT_MISS: assert property (@(posedge clk) disable iff (!rstN)
    !(respDone && memMiss)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone); // R10

  AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (respDone || memMiss) |-> reqReady); // R11

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2

  AST_LATENCY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !respDone |-> $stable(lastLatency)); // R10

  AST_LATENCY_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    respDone |-> (lastLatency >= LAT_W'(2))); // R3

endmodule

bind cacheMissSeq cmsChecker #(.LAT_W(LAT_W)) u_cmsChecker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .respDone    (respDone),
  .memMiss     (memMiss),
  .lastLatency (lastLatency)
);

// File: tb/test_cacheMissSeq.sv
module test_cacheMissSeq;

  localparam int SRAM_CYC = 23;
  localparam int RATIO    = 4;
  localparam int LAT_W    = 8;

  logic             clk = 1'b0;
  logic             rstN;
  logic             reqValid;
  logic             reqIsData;
  logic             l1Hit;
  logic             l2Hit;
  logic             l3Hit;
  logic             reqReady;
  logic             respDone;
  logic             memMiss;
  logic [LAT_W-1:0] lastLatency;

  always #10 clk = ~clk;  // 50 MHz

  cacheMissSeq #(.SRAM_CYC(SRAM_CYC), .L3_RATIO(RATIO), .LAT_W(LAT_W)) i_cacheMissSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsData(reqIsData),
    .l1Hit(l1Hit), .l2Hit(l2Hit), .l3Hit(l3Hit), .reqReady(reqReady),
    .respDone(respDone), .memMiss(memMiss), .lastLatency(lastLatency)
  );

  // Reference model state
  int    ec = 0;
  int    nChk = 0;
  int    nBad = 0;
  bit    mBusy = 0;
  bit    mMiss = 0;
  int    mEnd = 0;
  int    mStart = 0;
  int    mLast = 0;
  string mTag = "R3";
  bit    noisy = 0;
  bit    finished = 0;

  task automatic chk(string tag, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d at edge %0d", tag, what, act, exp, ec);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  endtask

  // Schedule of a request accepted at edge tA, derived from R3..R9
  task automatic plan(string tag);
    int tA, base, tL, a, ret;
    tA     = ec + 1;
    mStart = tA;
    mMiss  = 0;
    mTag   = tag;
    ret    = reqIsData ? 2 : 4;
    base   = 2 + (reqIsData ? 1 : 3) + 1;
    if (l1Hit)      mEnd = tA + (reqIsData ? 3 : 2);
    else if (l2Hit) mEnd = tA + base + 3 + ret;
    else begin
      tL = tA + base + 4;
      if (!l3Hit) begin
        mMiss = 1;
        mEnd  = tL;
      end else begin
        a    = (RATIO - (tL % RATIO)) % RATIO;  // R7
        mEnd = tL + a + SRAM_CYC + ret;
      end
    end
    mBusy = 1;
  endtask

  task automatic tick(string tag);
    bit expDone, expMiss;
    if (!mBusy && reqValid && rstN) plan(tag);
    @(posedge clk);
    if (rstN) ec++;
    @(negedge clk);
    expDone = 0;
    expMiss = 0;
    if (mBusy && ec == mEnd) begin
      if (mMiss) expMiss = 1;
      else begin
        expDone = 1;
        mLast   = mEnd - mStart;
      end
      mBusy = 0;
    end
    chk("R2", "reqReady", int'(reqReady), int'(!mBusy));
    chk(mTag, "respDone", int'(respDone), int'(expDone));
    chk("R9", "memMiss", int'(memMiss), int'(expMiss));
    chk("R10", "lastLatency", int'(lastLatency), mLast);
  endtask

  task automatic idle(int n);
    reqValid = 0;
    for (int i = 0; i < n; i++) tick("R2");
  endtask

  task automatic send(bit isData, bit h1, bit h2, bit h3, string tag);
    while (mBusy) tick(mTag);
    reqValid  = 1;
    reqIsData = isData;
    l1Hit     = h1;
    l2Hit     = h2;
    l3Hit     = h3;
    tick(tag);
    reqValid = 0;
    while (mBusy) begin
      if (noisy) begin  // R2: activity while busy must be ignored
        reqValid  = 1;
        reqIsData = ~reqIsData;
        l1Hit     = 1;
      end
      tick(mTag);
    end
    reqValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    rstN = 0; reqValid = 0; reqIsData = 0; l1Hit = 0; l2Hit = 0; l3Hit = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reqReady in reset", int'(reqReady), 1);
    chk("R1", "respDone in reset", int'(respDone), 0);
    chk("R1", "memMiss in reset", int'(memMiss), 0);
    chk("R1", "lastLatency in reset", int'(lastLatency), 0);
    rstN = 1;
    idle(2);

    send(0, 1, 0, 0, "R3");     // instruction hit in L1: 2
    send(1, 1, 0, 0, "R3");     // data hit in L1: 3
    send(0, 0, 1, 0, "R4");     // 13
    send(1, 0, 1, 0, "R5");     // 9
    for (int g = 0; g < 4; g++) begin
      idle(g);
      send(0, 0, 0, 1, "R6");   // all alignment waits R7
    end
    for (int g = 0; g < 4; g++) begin
      idle(g);
      send(1, 0, 0, 1, "R7");
    end
    send(0, 0, 0, 0, "R9");
    send(1, 0, 0, 0, "R9");
    send(0, 1, 0, 0, "R11");    // back to back after a memory miss
    send(1, 0, 1, 0, "R11");    // back to back after a completion
    send(1, 1, 1, 1, "R8");     // L1 wins
    send(0, 0, 1, 1, "R8");     // L3 flag irrelevant on L2 hit
    noisy = 1;
    send(0, 0, 1, 0, "R2");
    noisy = 0;
    send(0, 0, 0, 1, "R2");
    idle(3);
    summary();
  end

endmodule